// File: doc/BRIEF.md
# Dual Parallel Port with Per-Bit Direction Control

This block gives a processor two 8-bit parallel ports on a small register bus. Each port has a value register and a direction register. A direction bit of 1 makes that bit an output. A direction bit of 0 leaves the bit as an input. The chip has no internal tristate nets, so each port has a separate output bus and a separate input bus.

The pins follow an open-collector, active-low convention. A bit configured as an output drives its stored value. A bit configured as an input drives a released level of 1. When the processor reads a port, it sees the wired-AND of the external input and the driven level. A bit therefore reads low when an outside device pulls it low, or when the port itself drives a 0. External inputs that are not used must be tied high. For example, five active-low switch lines can enter port A on bits 4..0, with bits 7..5 tied to 1.

Top module: `pio_dual_port`

## Requirements
- R1: After a synchronous active-low reset, every value and direction register is 0 (all bits inputs), both output buses are all ones, and the read data is 0.
- R2: A write with `wr_en` high to offset 0 loads the port A value register, and a write to offset 1 loads the port B value register, on that clock edge.
- R3: A write to offset 2 loads the port A direction register, and a write to offset 3 loads the port B direction register. A direction bit of 1 makes the bit an output. Reading offset 2 or 3 returns that direction register.
- R4: Each output bus bit equals the value register bit when its direction bit is 1, and equals 1 when its direction bit is 0.
- R5: Reading offset 0 returns `pa_in & ~(dirA & ~valA)`, bit by bit.
- R6: Reading offset 1 returns the same function computed from port B's input bus and registers.
- R7: `rdata` is loaded on a clock edge only when `wr_en` is low, and it becomes valid one cycle after the address is presented. When `wr_en` is high, `rdata` holds its value.
- R8: An external low always reads as 0, even on a bit that is driven high as an output. An external input tied high reads back the driven level.
- R9: Writing a register of one port changes neither the output bus nor the readback of the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | High for a write; low for a read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_out | output | 8 | Port A driven level (1 = released) |
| pa_in | input | 8 | Port A external level, active low |
| pb_out | output | 8 | Port B driven level (1 = released) |
| pb_in | input | 8 | Port B external level, active low |

## Verification
A table of direction, value and input bytes is applied to both ports. One of the bytes holds all eight direction/value/input combinations on its own bits. This separates a correct wired-AND from an OR, from an ungated driver, and from an inverted direction sense. Other rows use all-input, all-output and mixed direction words. These show whether the released level is a 1, and whether an external low overrides a driven high. Directed cases then check four things: the reset state, that `rdata` holds during writes, that each port is independent of the other, and a switch-style pattern with unused inputs tied high.

// File: rtl/pio_pkg.sv
// Package: shared widths and the register offset map of the dual parallel port.
// Assumes two ports. The offset bit order is behaviour: bit 0 selects the
// port, and bit 1 selects the value or direction register.
package pio_pkg;
    localparam int PORT_W  = 8;
    localparam int N_PORTS = 2;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] OFF_VAL_A = 2'd0;
    localparam logic [ADDR_W-1:0] OFF_VAL_B = 2'd1;
    localparam logic [ADDR_W-1:0] OFF_DIR_A = 2'd2;
    localparam logic [ADDR_W-1:0] OFF_DIR_B = 2'd3;

    typedef enum logic {SEL_VAL = 1'b0, SEL_DIR = 1'b1} reg_sel_e;
endpackage

// File: rtl/pio_port.sv
// One parallel port: a value register, a direction register, the driven
// output level and the wired-AND readback.
// Assumes: the external input is active low, and unused inputs are tied high.
module pio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_val,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] readback,
    output logic [W-1:0] dir_val
);
    logic [W-1:0] val_q;
    logic [W-1:0] dir_q;

    // Value register: loaded by its write strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (wr_val) val_q <= wdata;
    end

    // Direction register: 1 = output, cleared to all inputs by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Per-bit driver and wired-AND readback.
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Driven level: stored bit when output, released (1) when input.
        always_comb pin_out[b] = dir_q[b] ? val_q[b] : 1'b1;
        // Pin reads low if the outside pulls low or the port drives low.
        always_comb readback[b] = pin_in[b] & ~(dir_q[b] & ~val_q[b]);
    end

    assign dir_val = dir_q;

    // R2
    val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> val_q == $past(wdata));
    // R3
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(wdata));
    // R9
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_val && !wr_dir) |=> $stable(pin_out));
endmodule

// File: rtl/pio_regbus.sv
// Register bus: decodes the write strobes for each port and registers the
// read data selected by the offset.
// Assumes: a single-cycle access where wr_en high means a write.
module pio_regbus
    import pio_pkg::*;
#(
    parameter int W  = 8,
    parameter int NP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [NP-1:0][W-1:0] readback,
    input  logic [NP-1:0][W-1:0] dir_val,
    output logic [NP-1:0]        wr_val,
    output logic [NP-1:0]        wr_dir,
    output logic [W-1:0]         rdata
);
    reg_sel_e sel;
    logic     port_idx;

    assign sel      = reg_sel_e'(addr[1]);
    assign port_idx = addr[0];

    // Write strobe for each port's value and direction register.
    for (genvar p = 0; p < NP; p++) begin : g_dec
        always_comb begin
            wr_val[p] = wr_en && (sel == SEL_VAL) && (int'(port_idx) == p);
            wr_dir[p] = wr_en && (sel == SEL_DIR) && (int'(port_idx) == p);
        end
    end

    // Read register: loads only when no write is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (!wr_en) rdata <= (sel == SEL_DIR) ? dir_val[port_idx]
                                                   : readback[port_idx];
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rdata));
    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_val, wr_dir}));
endmodule

// File: rtl/pio_dual_port.sv
// Top: two parallel ports behind a four-offset register bus. There are no
// tristate pins; each port has a split output and input bus.
// Assumes: unused external inputs are tied high.
module pio_dual_port
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    output logic [PORT_W-1:0] pa_out,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pb_out,
    input  logic [PORT_W-1:0] pb_in
);
    logic [N_PORTS-1:0][PORT_W-1:0] pin_in_v;
    logic [N_PORTS-1:0][PORT_W-1:0] pin_out_v;
    logic [N_PORTS-1:0][PORT_W-1:0] rb_v;
    logic [N_PORTS-1:0][PORT_W-1:0] dir_v;
    logic [N_PORTS-1:0]             wr_val_v;
    logic [N_PORTS-1:0]             wr_dir_v;

    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign pa_out      = pin_out_v[0];
    assign pb_out      = pin_out_v[1];

    // One instance for each port.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        pio_port #(.W(PORT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_val   (wr_val_v[p]),
            .wr_dir   (wr_dir_v[p]),
            .wdata    (wdata),
            .pin_in   (pin_in_v[p]),
            .pin_out  (pin_out_v[p]),
            .readback (rb_v[p]),
            .dir_val  (dir_v[p])
        );
    end

    pio_regbus #(.W(PORT_W), .NP(N_PORTS)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .readback (rb_v),
        .dir_val  (dir_v),
        .wr_val   (wr_val_v),
        .wr_dir   (wr_dir_v),
        .rdata    (rdata)
    );

    // R8
    ext_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && addr == OFF_VAL_A) |=> (rdata & ~$past(pa_in)) == '0);
    // R8
    ext_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && addr == OFF_VAL_B) |=> (rdata & ~$past(pb_in)) == '0);
endmodule

// File: tb/test_pio_dual_port.sv
`timescale 1ns/1ps
module test_pio_dual_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pa_out, pb_out;
    logic [7:0] pa_in = 8'hFF;
    logic [7:0] pb_in = 8'hFF;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pio_dual_port i_pio_dual_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pa_out(pa_out), .pa_in(pa_in),
        .pb_out(pb_out), .pb_in(pb_in)
    );

    // Each row: {dir, value, input, expected out, expected readback}
    localparam int NV = 8;
    localparam logic [NV-1:0][39:0] VEC = '{
        {8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF},
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00},
        {8'hF0, 8'hCC, 8'hAA, 8'hCF, 8'h8A},
        {8'h0F, 8'h5A, 8'hF0, 8'hFA, 8'hF0},
        {8'h3C, 8'h96, 8'hE7, 8'hD7, 8'hC7},
        {8'hAA, 8'h55, 8'hFF, 8'h55, 8'h55},
        {8'h55, 8'h55, 8'hE0, 8'hFF, 8'hE0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pa_out", pa_out, 8'hFF);
        check("R1 pb_out", pb_out, 8'hFF);
        check("R1 rdata", rdata, 8'h00);
        rst_n = 1'b1;
        rd(2'd2, r); check("R1 dirA", r, 8'h00);
        rd(2'd3, r); check("R1 dirB", r, 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0] vd, vv, vi, eo, er;
            {vd, vv, vi, eo, er} = VEC[i];
            wr(2'd2, vd); wr(2'd0, vv);
            wr(2'd3, vd); wr(2'd1, vv);
            pa_in = vi; pb_in = vi;
            @(negedge clk);
            check("R4 pa_out", pa_out, eo);
            check("R4 pb_out", pb_out, eo);
            rd(2'd0, r); check("R5 R8 readA", r, er);
            rd(2'd1, r); check("R6 readB", r, er);
            rd(2'd2, r); check("R3 dirA", r, vd);
            rd(2'd3, r); check("R3 dirB", r, vd);
        end

        // R9 isolation: port A changes, port B stays put
        pa_in = 8'hFF; pb_in = 8'hFF;
        wr(2'd3, 8'hFF); wr(2'd1, 8'h3C);
        wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
        @(negedge clk);
        check("R9 pb_out", pb_out, 8'h3C);
        rd(2'd1, r); check("R9 readB", r, 8'h3C);
        check("R2 pa_out", pa_out, 8'h00);

        // R7 rdata holds while a write is in progress
        rd(2'd1, r);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd2; wdata = 8'h81;
        @(negedge clk);
        check("R7 hold", rdata, 8'h3C);
        wr_en = 1'b0;
        @(negedge clk);
        check("R7 load after write", rdata, 8'h81);

        // R8 switch lines on A[4:0], A[7:5] tied high, A all-output high
        wr(2'd2, 8'hFF); wr(2'd0, 8'hFF);
        pa_in = {3'b111, 5'b10110};
        rd(2'd0, r); check("R8 switches", r, 8'hF6);

        // R1 reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 pa_out after reset", pa_out, 8'hFF);
        check("R1 pb_out after reset", pb_out, 8'hFF);
        check("R1 rdata after reset", rdata, 8'h00);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule